// File: doc/BRIEF.md
# One-Second Tick Time-of-Day Counter

This block keeps wall-clock time (seconds, minutes, hours) from a slow count enable that pulses at 32.768 kHz inside a faster system clock domain. A timebase counter of `CNT_W` bits (16 by default) advances once per enable. Left alone it would wrap every 2^CNT_W enables, which is two seconds. Instead, on every wrap the counter's top bit is forced high in the same cycle. The remaining bits keep counting, so each later wrap comes exactly 2^(CNT_W-1) enables (one second) after the previous one. The low part of the counter is never rewritten, so rounding error cannot build up over time.

Every timebase wrap advances the seconds unit and raises a one-cycle pulse. A seconds rollover carries into minutes, and a minutes rollover carries into hours. Software-side logic sets the time with a single load strobe. The strobe writes all three units together and restarts the timebase half-way, so the first second after a load is a full second.

Inside, each counter decodes its next action into a named enumerated value with a `unique case`. The timebase actions are `TB_HOLD`, `TB_COUNT`, `TB_WRAP` and `TB_LOAD`. Each time unit has the actions `CA_HOLD`, `CA_INC`, `CA_WRAP` and `CA_LOAD`. The transitions are:
- `TB_LOAD` / `CA_LOAD` on a load strobe.
- `TB_WRAP` when the enable meets an all-ones counter.
- `TB_COUNT` on any other enable.
- `CA_WRAP` when a step reaches a unit at or past its last value.
- `CA_INC` on any other step.

Top module: `rtc_tick_clock`

## Requirements
- R1: While `rst_n` is low, the timebase clears to zero, all three time outputs read 0, and `sec_pulse` is 0.
- R2: A cycle with neither `tick_en` nor `load_en` changes no output and leaves the timebase where it was.
- R3: From reset, the first wrap happens on the 2^CNT_W-th enable. A wrap sets the counter to its top bit alone (FFFFh becomes 8000h), and every later wrap comes 2^(CNT_W-1) enables after the one before.
- R4: `sec_pulse` is high for exactly one clock cycle, in the cycle after the edge that consumed the wrapping enable. It is never high in two cycles in a row.
- R5: Seconds advance by one on the same edge that raises `sec_pulse`, and wrap from 59 to 0.
- R6: A seconds wrap advances minutes, which wrap from 59 to 0. A minutes wrap advances hours, which wrap from 23 to 0.
- R7: A `load_en` cycle writes `load_sec`, `load_min` and `load_hr`, which are visible after that edge. It sets the timebase to its top bit alone, so the next pulse follows 2^(CNT_W-1) enables, and it raises no pulse.
- R8: When `load_en` and `tick_en` are high together, the load wins and the enable is dropped.
- R9: A unit loaded above its range (for example seconds 62) wraps to 0 on its next step and carries into the next unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle count enable at 32.768 kHz |
| load_en | input | 1 | Time-load strobe |
| load_sec | input | 6 | Seconds value to load |
| load_min | input | 6 | Minutes value to load |
| load_hr | input | 5 | Hours value to load |
| sec | output | 6 | Current seconds |
| min | output | 6 | Current minutes |
| hr | output | 5 | Current hours |
| sec_pulse | output | 1 | One-cycle pulse per elapsed second |

## Verification
The counter is driven with back-to-back enables and with sparse enables that have idle gaps. The two patterns must give the same second boundaries, which separates counting enables from counting clocks. An idle stretch with no enables shows whether anything advances on its own. The first period after reset (a full wrap) is contrasted with later periods (half wraps), which exposes a missing or misplaced top-bit preload. Loads placed just before the 23:59:59 rollover, at an out-of-range value, and in the same cycle as an enable exercise the carry chain, the wrap comparison and load precedence.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int SEC_W     = 6;
    localparam int MIN_W     = 6;
    localparam int HR_W      = 5;
    localparam int SEC_LIMIT = 60;
    localparam int MIN_LIMIT = 60;
    localparam int HR_LIMIT  = 24;

    // Action chosen by the timebase for the current cycle
    typedef enum logic [1:0] {
        TB_HOLD,
        TB_COUNT,
        TB_WRAP,
        TB_LOAD
    } tb_act_e;

    // Action chosen by one time unit for the current cycle
    typedef enum logic [1:0] {
        CA_HOLD,
        CA_INC,
        CA_WRAP,
        CA_LOAD
    } cnt_act_e;

endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase
    import rtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic load_en,
    output logic step,
    output logic sec_pulse
);

    localparam logic [CNT_W-1:0] MSB_ONLY = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
    localparam logic [CNT_W-2:0] LOW_ONE  = (CNT_W-1)'(1);

    logic [CNT_W-1:0] count;
    tb_act_e          act;

    // Action decode: load has precedence over the enable
    always_comb begin
        if (load_en)
            act = TB_LOAD;
        else if (tick_en && (&count))
            act = TB_WRAP;
        else if (tick_en)
            act = TB_COUNT;
        else
            act = TB_HOLD;
    end

    assign step = (act == TB_WRAP);

    // Counter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (act)
                TB_HOLD:  count <= count;
                TB_COUNT: count <= count + ONE;
                TB_WRAP:  count <= {1'b1, count[CNT_W-2:0] + LOW_ONE};
                TB_LOAD:  count <= MSB_ONLY;
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sec_pulse <= 1'b0;
        else
            sec_pulse <= (act == TB_WRAP);
    end

    p_wrap_preload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !load_en && (&count)) |=> (count == MSB_ONLY) && sec_pulse);

    p_msb_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count[CNT_W-1] |=> count[CNT_W-1]);

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> !sec_pulse);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load_en) |=> $stable(count) && !sec_pulse);

    p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (count == MSB_ONLY) && !sec_pulse);

endmodule

// File: rtl/rtc_wrap_counter.sv
module rtc_wrap_counter
    import rtc_pkg::*;
#(
    parameter int W     = 6,
    parameter int LIMIT = 60
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value,
    output logic         at_last
);

    localparam logic [W-1:0] LAST = W'(LIMIT - 1);
    localparam logic [W-1:0] ONE  = W'(1);

    cnt_act_e act;

    // Values at or beyond the last legal value wrap on the next step
    assign at_last = (value >= LAST);

    always_comb begin
        if (load_en)
            act = CA_LOAD;
        else if (step && at_last)
            act = CA_WRAP;
        else if (step)
            act = CA_INC;
        else
            act = CA_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else begin
            unique case (act)
                CA_HOLD: value <= value;
                CA_INC:  value <= value + ONE;
                CA_WRAP: value <= '0;
                CA_LOAD: value <= load_val;
            endcase
        end
    end

    p_wrap_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_en && at_last) |=> (value == '0));

    p_inc_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_en && !at_last) |=> (value == $past(value) + ONE));

    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (value == $past(load_val)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load_en) |=> $stable(value));

endmodule

// File: rtl/rtc_tick_clock.sv
module rtc_tick_clock
    import rtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load_en,
    input  logic [SEC_W-1:0] load_sec,
    input  logic [MIN_W-1:0] load_min,
    input  logic [HR_W-1:0]  load_hr,
    output logic [SEC_W-1:0] sec,
    output logic [MIN_W-1:0] min,
    output logic [HR_W-1:0]  hr,
    output logic             sec_pulse
);

    logic sec_step;
    logic min_step;
    logic hr_step;
    logic sec_last;
    logic min_last;
    logic hr_last;

    rtc_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .load_en   (load_en),
        .step      (sec_step),
        .sec_pulse (sec_pulse)
    );

    // Carry chain: each unit steps when all lower units wrap
    assign min_step = sec_step && sec_last;
    assign hr_step  = min_step && min_last;

    rtc_wrap_counter #(.W(SEC_W), .LIMIT(SEC_LIMIT)) u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (sec_step),
        .load_en  (load_en),
        .load_val (load_sec),
        .value    (sec),
        .at_last  (sec_last)
    );

    rtc_wrap_counter #(.W(MIN_W), .LIMIT(MIN_LIMIT)) u_min (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (min_step),
        .load_en  (load_en),
        .load_val (load_min),
        .value    (min),
        .at_last  (min_last)
    );

    rtc_wrap_counter #(.W(HR_W), .LIMIT(HR_LIMIT)) u_hr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (hr_step),
        .load_en  (load_en),
        .load_val (load_hr),
        .value    (hr),
        .at_last  (hr_last)
    );

    p_sec_with_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !$past(load_en) && $changed(sec)) |-> sec_pulse);

    p_min_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && sec_pulse && (sec == '0)) |-> (min != $past(min) || hr_last || $past(min) == '0));

    p_hr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hr_step && !hr_last) |=> (hr != '0));

endmodule

// File: tb/rtc_tick_clock_tb.sv
module rtc_tick_clock_tb;

    localparam int TB_W     = 8;
    localparam int FULL     = 1 << TB_W;
    localparam int HALF     = 1 << (TB_W - 1);
    localparam int WATCHDOG = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       load_en = 1'b0;
    logic [5:0] load_sec = '0;
    logic [5:0] load_min = '0;
    logic [4:0] load_hr = '0;
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hr;
    logic       sec_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model
    int m_cnt = 0;
    int m_sec = 0;
    int m_min = 0;
    int m_hr  = 0;
    logic [16:0] exp_q[$];

    always #2.5 clk = ~clk;

    rtc_tick_clock #(.CNT_W(TB_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .load_en   (load_en),
        .load_sec  (load_sec),
        .load_min  (load_min),
        .load_hr   (load_hr),
        .sec       (sec),
        .min       (min),
        .hr        (hr),
        .sec_pulse (sec_pulse)
    );

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d:%0d:%0d expected %0d:%0d:%0d", req,
                     act[16:12], act[11:6], act[5:0], exp[16:12], exp[11:6], exp[5:0]);
        end
    endtask

    // Advance model time by one second (R5, R6, R9)
    task automatic model_second();
        if (m_sec >= 59) begin
            m_sec = 0;
            if (m_min >= 59) begin
                m_min = 0;
                m_hr  = (m_hr >= 23) ? 0 : m_hr + 1;
            end else begin
                m_min = m_min + 1;
            end
        end else begin
            m_sec = m_sec + 1;
        end
        exp_q.push_back({5'(m_hr), 6'(m_min), 6'(m_sec)});
    endtask

    // Driver: n enables, each followed by gap idle cycles
    task automatic run_ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            tick_en = 1'b1;
            m_cnt++;
            if (m_cnt == FULL) begin
                m_cnt = HALF;       // R3: top bit forced at wrap
                model_second();
            end
            for (int g = 0; g < gap; g++) begin
                @(posedge clk); #1;
                tick_en = 1'b0;
            end
        end
        @(posedge clk); #1;
        tick_en = 1'b0;
    endtask

    task automatic do_load(input int s, input int m, input int h, input bit with_tick);
        @(posedge clk); #1;
        load_en  = 1'b1;
        tick_en  = with_tick;
        load_sec = 6'(s);
        load_min = 6'(m);
        load_hr  = 5'(h);
        @(posedge clk); #1;
        load_en = 1'b0;
        tick_en = 1'b0;
        m_sec = s; m_min = m; m_hr = h;
        m_cnt = HALF;   // R7 / R8: enable dropped, timebase at top bit only
        check(with_tick ? "R8" : "R7", {hr, min, sec}, {5'(h), 6'(m), 6'(s)});
        checks++;
        if (sec_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R7 pulse on load actual %0b expected 0", sec_pulse);
        end
    endtask

    // Monitor: pop expected time on every pulse
    logic prev_pulse = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sec_pulse && prev_pulse) begin
                checks++; errors++;
                $display("FAIL R4 pulse width actual 2+ cycles expected 1");
            end
            if (sec_pulse) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R3 unexpected pulse at %0d:%0d:%0d expected none", hr, min, sec);
                end else begin
                    check("R5/R6", {hr, min, sec}, exp_q.pop_front());
                end
            end
            prev_pulse <= sec_pulse;
        end
    end

    task automatic expect_drained(input string req);
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s missing pulses actual %0d pending expected 0", req, exp_q.size());
            exp_q.delete();
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1", {hr, min, sec}, 17'd0);
        checks++;
        if (sec_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R1 pulse actual %0b expected 0", sec_pulse);
        end
        rst_n = 1'b1;

        // R3: first period full, later periods half
        run_ticks(FULL - 1, 0);
        check("R3", {hr, min, sec}, 17'd0);
        run_ticks(1 + 3 * HALF, 0);
        expect_drained("R3");
        check("R5", {hr, min, sec}, {5'd0, 6'd0, 6'd4});

        // R2: idle cycles change nothing
        repeat (40) @(posedge clk);
        #1;
        check("R2", {hr, min, sec}, {5'd0, 6'd0, 6'd4});

        // R2: sparse enables count enables, not clocks
        run_ticks(2 * HALF, 2);
        expect_drained("R2");
        check("R2", {hr, min, sec}, {5'd0, 6'd0, 6'd6});

        // R6: full-day rollover
        do_load(58, 59, 23, 1'b0);
        run_ticks(3 * HALF, 0);
        expect_drained("R6");

        // R6: minute carry without hour wrap
        do_load(59, 58, 5, 1'b0);
        run_ticks(2 * HALF, 1);
        expect_drained("R6");
        check("R6", {hr, min, sec}, {5'd5, 6'd59, 6'd1});

        // R8: load with simultaneous enable
        do_load(10, 5, 3, 1'b1);
        run_ticks(HALF - 1, 0);
        check("R8", {hr, min, sec}, {5'd3, 6'd5, 6'd10});
        run_ticks(1, 0);
        expect_drained("R8");

        // R9: out-of-range values wrap and carry
        do_load(62, 61, 30, 1'b0);
        run_ticks(HALF, 0);
        expect_drained("R9");
        check("R9", {hr, min, sec}, 17'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule